// File: doc/BRIEF.md
# Signalling-Channel Access Priority Arbiter

This block decides when a local frame controller on a time-multiplexed serial bus may start sending on the shared upstream signalling channel. That channel is also used by remote terminals on the line side. The arbiter watches each upstream channel bit as it passes and counts unbroken runs of ones. When the run reaches the selected priority threshold and a local controller is asking for the channel, it grants the channel straight away. While the local grant is held, the echo bits returned to the line side are inverted. Remote terminals therefore see a collision and hold back.

The upstream device can halt every source with a stop bit. Releasing a grant restarts the count from zero, so a source that has just finished has to wait for a full idle run like everyone else. This gives local sources and remote terminals equal access. The block has no input for the line-side special/group indication, because that indication plays no part in this mode.

The control is a three-state machine:
- **LISTEN** counts ones.
- **OWNED** holds a local grant.
- **HALTED** is entered while the upstream stop bit is low.

Its transitions are:
- LISTEN→OWNED when the run is long enough and the request bit is low.
- LISTEN→HALTED and OWNED→HALTED when the stop bit is low.
- OWNED→LISTEN when the request bit returns high.
- HALTED→LISTEN when the stop bit returns high.
- Reset forces LISTEN.

Top module: `dch_prio_arbiter`

## Requirements
- R1: The ones counter changes only on a clock edge where `bit_valid` is high. Without the strobe, `run_len` holds its value.
- R2: A strobed upstream bit of value 0 clears `run_len` to 0 at that edge.
- R3: A strobed bit of value 1 increments `run_len` until it reaches the threshold, and the counter then saturates there. The threshold is 8 when `prio_ten` is 0 and 10 when `prio_ten` is 1.
- R4: `run_done` is high exactly when `run_len` is greater than or equal to the threshold currently selected by `prio_ten`.
- R5: In LISTEN, when `run_done` is high, `req_n` is 0 (0 means request) and `stop_n` is 1, the machine moves to OWNED at that edge. `granted` is high from then on. No other path raises `granted`.
- R6: `echo_out` equals `line_bit` inverted while `granted` is high, and equals `line_bit` otherwise. It is combinational, with no cycle of delay.
- R7: When `stop_n` is 0 at an edge, the machine is in HALTED after that edge. `granted` is low and `run_len` is held at 0 for as long as `stop_n` stays 0.
- R8: When `req_n` is 1 in OWNED, `granted` drops at that edge and `run_len` is 0 after it. A new grant then needs a full threshold count of fresh ones.
- R9: While the synchronous active-high `rst` is high at an edge, the block is in LISTEN after that edge, with `run_len` 0, `granted` low and no echo inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One-cycle strobe marking a valid upstream channel bit |
| up_bit | input | 1 | Upstream channel bit value on the local bus |
| req_n | input | 1 | Local access request, 0 = requesting |
| stop_n | input | 1 | Upstream stop control, 0 = halt all sources |
| prio_ten | input | 1 | Threshold select: 0 = 8 ones, 1 = 10 ones |
| line_bit | input | 1 | Received channel bit to be echoed to the line side |
| granted | output | 1 | Local source owns the channel |
| echo_out | output | 1 | Echo bit sent to the line side |
| run_done | output | 1 | Current run of ones meets the threshold |
| run_len | output | 4 | Current count of consecutive ones |

## Verification
Counter and machine results are registered. A strobe or a request applied in one cycle appears on `run_len`, `run_done` and `granted` only after the next rising edge. A grant therefore shows up one edge after the edge at which the count reaches the threshold. The echo result is combinational and is due in the same cycle as `line_bit`. The bench drives inputs just after the falling edge and waits a short settling delay. It then compares the outputs against a cycle model that has been advanced once per rising edge, so each registered result is checked exactly one edge after its cause and the echo in the cycle of its stimulus.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;

    // Arbitration machine states
    typedef enum logic [1:0] {
        ARB_LISTEN = 2'd0,
        ARB_OWNED  = 2'd1,
        ARB_HALTED = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dch_run_counter.sv
module dch_run_counter #(
    parameter int THR_LO = 8,
    parameter int THR_HI = 10,
    parameter int CNT_W  = $clog2(THR_HI + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_clr,
    input  logic             bit_valid,
    input  logic             up_bit,
    input  logic             prio_ten,
    output logic [CNT_W-1:0] run_len,
    output logic             run_done
);

    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(THR_LO);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(THR_HI);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = prio_ten ? LIM_HI : LIM_LO;
    end

    // Next count: cleared outside listening, reset by zeros, saturating on ones
    always_comb begin
        cnt_d = cnt_q;
        if (hold_clr) begin
            cnt_d = '0;
        end else if (bit_valid) begin
            if (!up_bit) begin
                cnt_d = '0;
            end else if (cnt_q < limit) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign run_len  = cnt_q;
    assign run_done = (cnt_q >= limit);

    // R1: no strobe, no clear -> count holds
    p_strobe_only_r1: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !hold_clr) |=> $stable(cnt_q));

    // R2: strobed zero clears the count
    p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !up_bit) |=> (cnt_q == '0));

    // R3: a full run does not advance further
    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        (!hold_clr && bit_valid && up_bit && (cnt_q >= limit)) |=> $stable(cnt_q));

endmodule

// File: rtl/dch_arb_fsm.sv
module dch_arb_fsm
    import dch_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_done,
    input  logic       req_n,
    input  logic       stop_n,
    output arb_state_e state,
    output logic       granted,
    output logic       hold_clr
);

    arb_state_e st_q;
    arb_state_e st_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ARB_LISTEN;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_LISTEN: begin
                if (!stop_n) begin
                    st_d = ARB_HALTED;
                end else if (run_done && !req_n) begin
                    st_d = ARB_OWNED;
                end
            end
            ARB_OWNED: begin
                if (!stop_n) begin
                    st_d = ARB_HALTED;
                end else if (req_n) begin
                    st_d = ARB_LISTEN;
                end
            end
            ARB_HALTED: begin
                if (stop_n) begin
                    st_d = ARB_LISTEN;
                end
            end
            default: st_d = ARB_LISTEN;
        endcase
    end

    // Outputs
    always_comb begin
        granted  = 1'b0;
        hold_clr = 1'b1;
        unique case (st_q)
            ARB_LISTEN: begin
                granted  = 1'b0;
                hold_clr = 1'b0;
            end
            ARB_OWNED: begin
                granted  = 1'b1;
                hold_clr = 1'b1;
            end
            ARB_HALTED: begin
                granted  = 1'b0;
                hold_clr = 1'b1;
            end
            default: begin
                granted  = 1'b0;
                hold_clr = 1'b1;
            end
        endcase
    end

    assign state = st_q;

    // R5: a grant only starts from a complete run with a pending request
    p_grant_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(granted) |-> $past(run_done && !req_n && stop_n));

    // R7: stop removes any grant at the next edge
    p_stop_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        !stop_n |=> (!granted && state == ARB_HALTED));

endmodule

// File: rtl/dch_echo_ctrl.sv
module dch_echo_ctrl (
    input  logic granted,
    input  logic line_bit,
    output logic echo_out
);

    // Invert the echo toward the line only while the local side owns the channel
    always_comb begin
        if (granted) begin
            echo_out = ~line_bit;
        end else begin
            echo_out = line_bit;
        end
    end

endmodule

// File: rtl/dch_prio_arbiter.sv
module dch_prio_arbiter
    import dch_arb_pkg::*;
#(
    parameter int THR_LO = 8,
    parameter int THR_HI = 10,
    parameter int CNT_W  = $clog2(THR_HI + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             up_bit,
    input  logic             req_n,
    input  logic             stop_n,
    input  logic             prio_ten,
    input  logic             line_bit,
    output logic             granted,
    output logic             echo_out,
    output logic             run_done,
    output logic [CNT_W-1:0] run_len
);

    arb_state_e state;
    logic       hold_clr;

    dch_run_counter #(
        .THR_LO (THR_LO),
        .THR_HI (THR_HI),
        .CNT_W  (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .hold_clr  (hold_clr),
        .bit_valid (bit_valid),
        .up_bit    (up_bit),
        .prio_ten  (prio_ten),
        .run_len   (run_len),
        .run_done  (run_done)
    );

    dch_arb_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run_done (run_done),
        .req_n    (req_n),
        .stop_n   (stop_n),
        .state    (state),
        .granted  (granted),
        .hold_clr (hold_clr)
    );

    dch_echo_ctrl u_echo (
        .granted  (granted),
        .line_bit (line_bit),
        .echo_out (echo_out)
    );

    // R8: release drops the grant and restarts the count
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (granted && req_n && stop_n) |=> (!granted && run_len == '0));

    // R7: count is held at zero while stopped
    p_stop_count_r7: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && state == ARB_HALTED) |=> (run_len == '0));

    // R9: reset leaves the idle state
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!granted && run_len == '0 && state == ARB_LISTEN));

endmodule

// File: tb/dch_prio_arbiter_bench.sv
module dch_prio_arbiter_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       up_bit = 1'b0;
    logic       req_n = 1'b1;
    logic       stop_n = 1'b1;
    logic       prio_ten = 1'b0;
    logic       line_bit = 1'b0;
    logic       granted;
    logic       echo_out;
    logic       run_done;
    logic [3:0] run_len;

    dch_prio_arbiter u_dch_prio_arbiter (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .up_bit    (up_bit),
        .req_n     (req_n),
        .stop_n    (stop_n),
        .prio_ten  (prio_ten),
        .line_bit  (line_bit),
        .granted   (granted),
        .echo_out  (echo_out),
        .run_done  (run_done),
        .run_len   (run_len)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Cycle model: 0 listen, 1 owned, 2 halted
    int m_state = 0;
    int m_cnt   = 0;
    bit m_valid = 1'b0;

    function automatic int thr_of(bit p);
        return p ? 10 : 8;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle; compare outputs with model; advance model over the next edge
    task automatic step(bit r, bit s, bit d, bit q, bit t, bit p, bit l);
        int ncnt;
        int nst;
        int thr;
        @(negedge clk);
        rst = r; bit_valid = s; up_bit = d; req_n = q;
        stop_n = t; prio_ten = p; line_bit = l;
        #1;
        thr = thr_of(p);
        if (m_valid) begin
            chk("R5 R7 R8 granted", int'(granted), (m_state == 1) ? 1 : 0);
            chk("R1 R2 R3 run_len", int'(run_len), m_cnt);
            chk("R4 run_done", int'(run_done), (m_cnt >= thr) ? 1 : 0);
            chk("R6 echo_out", int'(echo_out), int'(l ^ (m_state == 1)));
        end
        if (r) begin
            m_state = 0;
            m_cnt   = 0;
            m_valid = 1'b1;
        end else begin
            ncnt = m_cnt;
            nst  = m_state;
            if (m_state != 0) ncnt = 0;
            else if (s) ncnt = d ? ((m_cnt < thr) ? m_cnt + 1 : m_cnt) : 0;
            case (m_state)
                0: if (!t) nst = 2; else if (!q && m_cnt >= thr) nst = 1;
                1: if (!t) nst = 2; else if (q) nst = 0;
                default: if (t) nst = 0;
            endcase
            m_cnt   = ncnt;
            m_state = nst;
        end
    endtask

    task automatic ones(int n, bit q, bit t, bit p);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, q, t, p, 1'($urandom));
    endtask

    task automatic hold(bit q, bit t, bit p, bit l);
        step(1'b0, 1'b0, 1'b0, q, t, p, l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R9: reset state
        step(1, 0, 0, 1, 1, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0);
        hold(1, 1, 0, 1);
        chk("R9 granted after reset", int'(granted), 0);
        chk("R9 run_len after reset", int'(run_len), 0);
        chk("R9 echo not inverted", int'(echo_out), 1);

        // R3/R4: eight ones with threshold 8
        ones(8, 1, 1, 0);
        hold(1, 1, 0, 0);
        chk("R3 count reaches 8", int'(run_len), 8);
        chk("R4 run_done at 8", int'(run_done), 1);
        ones(3, 1, 1, 0);
        hold(1, 1, 0, 0);
        chk("R3 saturates at 8", int'(run_len), 8);

        // R1: no strobe, count holds
        hold(1, 1, 0, 0);
        hold(1, 1, 0, 0);
        hold(1, 1, 0, 0);
        chk("R1 holds without strobe", int'(run_len), 8);

        // R5/R6: request with full run -> immediate grant, inverted echo
        hold(0, 1, 0, 1);
        hold(0, 1, 0, 1);
        chk("R5 grant after request", int'(granted), 1);
        chk("R6 echo inverted", int'(echo_out), 0);

        // R8: release and restart
        hold(1, 1, 0, 1);
        hold(1, 1, 0, 1);
        chk("R8 grant dropped", int'(granted), 0);
        chk("R8 count restarted", int'(run_len), 0);
        ones(7, 0, 1, 0);
        hold(0, 1, 0, 0);
        chk("R8 no grant before full run", int'(granted), 0);
        ones(1, 0, 1, 0);
        hold(0, 1, 0, 0);
        hold(0, 1, 0, 0);
        chk("R5 grant after eighth one", int'(granted), 1);

        // R7: stop removes grant and blocks counting
        hold(0, 0, 0, 0);
        hold(0, 0, 0, 0);
        chk("R7 grant removed by stop", int'(granted), 0);
        ones(10, 0, 0, 0);
        hold(0, 0, 0, 0);
        chk("R7 no grant while stopped", int'(granted), 0);
        chk("R7 count held at zero", int'(run_len), 0);
        hold(1, 1, 0, 0);
        hold(1, 1, 0, 0);

        // R2: strobed zero clears
        ones(5, 1, 1, 0);
        step(0, 1, 0, 1, 1, 0, 0);
        hold(1, 1, 0, 0);
        chk("R2 zero clears count", int'(run_len), 0);

        // R3/R5: threshold 10
        ones(9, 0, 1, 1);
        hold(0, 1, 1, 0);
        hold(0, 1, 1, 0);
        chk("R3 no grant at 9 with threshold 10", int'(granted), 0);
        chk("R4 run_done low at 9", int'(run_done), 0);
        ones(1, 0, 1, 1);
        hold(0, 1, 1, 0);
        hold(0, 1, 1, 0);
        chk("R5 grant at 10", int'(granted), 1);
        hold(1, 1, 1, 0);
        hold(1, 1, 1, 0);

        // Constrained random against the model
        begin
            bit q = 1'b1;
            bit p = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                bit r = ($urandom_range(0, 199) == 0);
                bit s = ($urandom_range(0, 1) == 1);
                bit d = ($urandom_range(0, 99) < 88);
                bit t = ($urandom_range(0, 99) >= 4);
                if ($urandom_range(0, 15) == 0) q = ~q;
                if ($urandom_range(0, 63) == 0) p = ~p;
                step(r, s, d, q, t, p, 1'($urandom));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule